// File: doc/BRIEF.md
# Packed Lane Interleave Unit

This unit merges two 64-bit packed operands into one 64-bit word by alternating lanes from each operand. A lane is 1, 2 or 4 bytes wide, chosen by a two-bit size code. A single half-select bit chooses which lanes are used. When it is low, both operands give up the lower half of their lanes. When it is high, both give up the upper half. The chosen lanes are placed side by side in the result: one lane from the first operand, then the matching lane from the second operand, and so on.

The unit is registered. A request presented with `inValid` high produces its result and `outValid` on the next clock edge. While no request is presented, the output register keeps its last value. An illegal size code gives a zero result and raises an error flag, which is registered together with the result. Floating-point meaning, register file access and instruction decode are outside this block.

Top module: `lane_interleave`

## Requirements
- R1: A synchronous active-high reset `rst` clears `result` to zero and drives `outValid` and `sizeError` low.
- R2: Size code 2'b00 selects 1-byte lanes, 2'b01 selects 2-byte lanes and 2'b10 selects 4-byte lanes. Lanes are numbered from bit 0 upward. With the offset taken from R3, result lane 2*i is `srcA` lane (i+offset), and result lane 2*i+1 is `srcB` lane (i+offset). Here i runs over the pair count, which is (8/lane_bytes)/2.
- R3: With `upperHalf` = 0 the offset is 0. With `upperHalf` = 1 the offset equals the pair count: 4 for bytes, 2 for 2-byte lanes and 1 for 4-byte lanes.
- R4: Size code 2'b11 is illegal. It gives a `result` of zero and sets `sizeError` to 1. Every legal code gives `sizeError` = 0.
- R5: `outValid` is high in exactly the cycle after a cycle in which `inValid` is high, and low otherwise.
- R6: While `inValid` is low, `result` and `sizeError` keep their values.
- R7: Each accepted request overwrites all 64 bits of `result`. No bit of the previous result survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| srcA | input | 64 | First packed operand; fills the even result lanes |
| srcB | input | 64 | Second packed operand; fills the odd result lanes |
| laneSize | input | 2 | Lane size code: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = illegal |
| upperHalf | input | 1 | 0 = use the lower half of the lanes, 1 = use the upper half |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | 64 | Interleaved word |
| sizeError | output | 1 | Set when the accepted request had an illegal size code |

## Verification
Every size code is swept against both half-select values. Each combination is tried with several operand patterns, and each pattern separates a different kind of fault:
- Byte-indexed counting operands, with a distinct high nibble per operand, expose any lane that comes from the wrong source or the wrong index.
- All-ones against all-zeros operands show which operand feeds the even result lanes and which feeds the odd ones.
- Mixed arithmetic constants catch swapped halves and wrong lane widths.

An all-ones result followed by all-zero operands shows that the whole word is overwritten. Idle cycles with changing inputs show that the output register holds its value and that the valid strobe drops.

// File: rtl/lane_interleave_pkg.sv
package lane_interleave_pkg;
  // Number of legal lane sizes: 1, 2 and 4 bytes (8 << code bits)
  localparam int NUM_SIZES = 3;
  localparam int CODE_W = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic                 upper;
    logic [NUM_SIZES-1:0] sizeOneHot;
  } ilv_ctrl_t;
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import lane_interleave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CODE_W-1:0] laneSize,
  input  logic              upperHalf,
  output ilv_ctrl_t         ctrl,
  output logic              outValid,
  output logic              sizeError
);
  logic [NUM_SIZES-1:0] oneHot;
  logic illegal;

  // One decode bit per legal size code
  generate
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_dec
      assign oneHot[k] = (laneSize == CODE_W'(k));
    end
  endgenerate

  assign illegal = ~|oneHot;

  always_comb begin
    ctrl.load       = inValid;
    ctrl.upper      = upperHalf;
    ctrl.sizeOneHot = oneHot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      sizeError <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) sizeError <= illegal;
    end
  end
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import lane_interleave_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  ilv_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] perSize [NUM_SIZES];
  logic [DATA_W-1:0] nextResult;

  // One interleave network for each legal lane width
  generate
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int LB    = 8 << k;
      localparam int LANES = DATA_W / LB;
      localparam int PAIRS = LANES / 2;

      logic [DATA_W-1:0] loWord;
      logic [DATA_W-1:0] hiWord;

      for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign loWord[(2*i)*LB   +: LB] = srcA[i*LB +: LB];
        assign loWord[(2*i+1)*LB +: LB] = srcB[i*LB +: LB];
        assign hiWord[(2*i)*LB   +: LB] = srcA[(i+PAIRS)*LB +: LB];
        assign hiWord[(2*i+1)*LB +: LB] = srcB[(i+PAIRS)*LB +: LB];
      end

      assign perSize[k] = ctrl.upper ? hiWord : loWord;
    end
  endgenerate

  // AND-OR select; an illegal code selects nothing and yields zero
  always_comb begin
    nextResult = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (ctrl.sizeOneHot[k]) nextResult = nextResult | perSize[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            result <= '0;
    else if (ctrl.load) result <= nextResult;
  end
endmodule

// File: rtl/lane_interleave.sv
module lane_interleave
  import lane_interleave_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [CODE_W-1:0] laneSize,
  input  logic              upperHalf,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              sizeError
);
  ilv_ctrl_t ctrl;

  ilv_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .laneSize(laneSize),
    .upperHalf(upperHalf), .ctrl(ctrl), .outValid(outValid),
    .sizeError(sizeError)
  );

  ilv_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .result(result)
  );
endmodule

// File: rtl/lane_interleave_checker.sv
module lane_interleave_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [7:0]  aLow,
  input logic [7:0]  bLow,
  input logic [31:0] aHigh,
  input logic [31:0] bHigh,
  input logic [1:0]  laneSize,
  input logic        upperHalf,
  input logic        outValid,
  input logic [63:0] result,
  input logic        sizeError
);
  // R5: strobe follows request by one cycle
  p_valid_follows_r5: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_drops_r5: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R4: illegal code zeroes the result and flags; legal codes do not flag
  p_illegal_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneSize == 2'b11) |=> (result == 64'd0 && sizeError));
  p_legal_noerr_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneSize != 2'b11) |=> !sizeError);

  // R6: no request, no change
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(result) && $stable(sizeError)));

  // R2: lowest byte pair in byte mode, lower half
  p_byte_low_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneSize == 2'b00 && !upperHalf) |=>
      (result[7:0] == $past(aLow) && result[15:8] == $past(bLow)));

  // R3: upper word of each source in 4-byte mode
  p_word_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneSize == 2'b10 && upperHalf) |=>
      (result == {$past(bHigh), $past(aHigh)}));
endmodule

bind lane_interleave lane_interleave_checker chk_i (
  .clk(clk), .rst(rst), .inValid(inValid),
  .aLow(srcA[7:0]), .bLow(srcB[7:0]),
  .aHigh(srcA[63:32]), .bHigh(srcB[63:32]),
  .laneSize(laneSize), .upperHalf(upperHalf), .outValid(outValid),
  .result(result), .sizeError(sizeError)
);

// File: tb/lane_interleave_tb.sv
module lane_interleave_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [63:0] srcA, srcB;
  logic [1:0]  laneSize;
  logic        upperHalf;
  logic        outValid;
  logic [63:0] result;
  logic        sizeError;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  lane_interleave dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .laneSize(laneSize), .upperHalf(upperHalf), .outValid(outValid),
    .result(result), .sizeError(sizeError)
  );

  function automatic logic [63:0] refIlv(input logic [63:0] a, input logic [63:0] b,
                                         input logic [1:0] code, input logic up);
    logic [63:0] r = 64'd0;
    int lb, pairs, off;
    logic [63:0] m;
    if (code == 2'b11) return 64'd0;
    lb    = 8 << code;
    pairs = (64 / lb) / 2;
    off   = up ? pairs : 0;
    m     = (64'd1 << lb) - 64'd1;
    for (int i = 0; i < pairs; i++) begin
      r = r | (((a >> ((i + off) * lb)) & m) << ((2 * i) * lb));
      r = r | (((b >> ((i + off) * lb)) & m) << ((2 * i + 1) * lb));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one request, then sample one cycle later (away from the edge)
  task automatic runOp(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] code, input logic up);
    @(negedge clk);
    srcA = a; srcB = b; laneSize = code; upperHalf = up; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(code == 2'b11 ? "R4 result" : (up ? "R3 result" : "R2 result"),
          result, refIlv(a, b, code, up));
    check("R4 sizeError", {63'd0, sizeError}, {63'd0, code == 2'b11});
    check("R5 outValid", {63'd0, outValid}, 64'd1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pa [6];
    logic [63:0] pb [6];
    logic [63:0] held;
    pa[0] = 64'h0706050403020100; pb[0] = 64'hF7F6F5F4F3F2F1F0;
    pa[1] = 64'hFFFFFFFFFFFFFFFF; pb[1] = 64'd0;
    pa[2] = 64'd0;                pb[2] = 64'hFFFFFFFFFFFFFFFF;
    pa[3] = 64'h0123456789ABCDEF; pb[3] = 64'hFEDCBA9876543210;
    pa[4] = 64'h9E3779B97F4A7C15; pb[4] = 64'h9E3779B97F4A7C15 * 64'd3;
    pa[5] = 64'hA5A5A5A55A5A5A5A; pb[5] = 64'h3C3C3C3CC3C3C3C3;

    rst = 1'b1; inValid = 1'b0; srcA = '1; srcB = '1; laneSize = 2'b00; upperHalf = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 result", result, 64'd0);
    check("R1 outValid", {63'd0, outValid}, 64'd0);
    check("R1 sizeError", {63'd0, sizeError}, 64'd0);
    rst = 1'b0;

    // R2 R3 R4 R5: every size code x half x pattern
    for (int c = 0; c < 4; c++)
      for (int h = 0; h < 2; h++)
        for (int p = 0; p < 6; p++)
          runOp(pa[p], pb[p], 2'(c), 1'(h));

    // R6: idle cycles with changing inputs keep the output
    runOp(pa[3], pb[3], 2'b01, 1'b1);
    held = result;
    srcA = pa[4]; srcB = pb[4]; laneSize = 2'b11; upperHalf = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 result hold", result, held);
    check("R6 sizeError hold", {63'd0, sizeError}, 64'd0);
    check("R5 outValid idle", {63'd0, outValid}, 64'd0);

    // R6: error flag also holds when idle
    runOp(pa[0], pb[0], 2'b11, 1'b0);
    srcA = pa[5]; laneSize = 2'b00;
    repeat (2) @(negedge clk);
    check("R6 error hold", {63'd0, sizeError}, 64'd1);

    // R7: full overwrite of an all-ones result
    runOp('1, '1, 2'b00, 1'b0);
    runOp(64'd0, 64'd0, 2'b00, 1'b1);
    check("R7 overwrite", result, 64'd0);
    runOp('1, '1, 2'b10, 1'b0);
    runOp(64'h00000000FFFFFFFF, 64'h00000000FFFFFFFF, 2'b10, 1'b1);
    check("R7 overwrite upper", result, 64'd0);

    // R5: back-to-back requests keep the strobe high
    @(negedge clk);
    srcA = pa[3]; srcB = pb[3]; laneSize = 2'b00; upperHalf = 1'b0; inValid = 1'b1;
    @(negedge clk);
    check("R5 stream first", result, refIlv(pa[3], pb[3], 2'b00, 1'b0));
    laneSize = 2'b01; upperHalf = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R5 stream valid", {63'd0, outValid}, 64'd1);
    check("R5 stream second", result, refIlv(pa[3], pb[3], 2'b01, 1'b1));

    // R1: reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 re-reset result", result, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule